// File: doc/BRIEF.md
# Windowed Watchdog Timer

A supervision timer built around a free-running 7-bit down-counter. The counter steps once per tick. A tick comes from the peripheral clock divided by a fixed ratio and then by a power of two that software selects. Once the watchdog is armed, software must reload the counter inside a time window. The window opens when the count falls to or below a programmed window value. It closes when bit 6 of the count would clear. A reload that comes too early, or a count that runs out, produces a one-cycle reset request for the system reset logic.

An early-warning flag is set when the count reaches 0x40, one tick before the timeout. This gives software a last chance to service the timer. The flag can drive an interrupt output. Arming is one-way: it can be set by a register write or forced by a strap input, and only the block reset clears it. Writing the control register with the arm bit set and bit 6 clear is a deliberate way to request a software reset.

Software reaches the block through three word registers on a simple write strobe and address bus. Reads are combinational on the address.

Top module: `win_watchdog`

## Requirements
- R1: The counter decrements by one on every tick, whether or not the watchdog is armed, and wraps from 0x00 to 0x7F. A control write loads bits [6:0] of the written word into the counter instead.
- R2: A tick occurs once every FIX_DIV × 2^psel clock cycles. A control write does not restart the dividers, so the first tick after a reload comes 1 to FIX_DIV × 2^psel cycles after the write edge.
- R3: With the strap low, the watchdog is disarmed after reset. A control write with bit 7 set arms it. Control writes with bit 7 clear leave it armed, and only rst_n disarms it.
- R4: With the strap `hw_arm` high, the watchdog reads as armed from reset, and writes cannot disarm it.
- R5: While armed, a tick taken with the count at 0x40 and no control write in that cycle raises `wd_rst`.
- R6: A control write that leaves the watchdog armed raises `wd_rst` if the current count is greater than the window value. A count equal to or below the window, but at least 0x40, gives no reset.
- R7: A control write that leaves the watchdog armed, with bit 6 of the written word clear, raises `wd_rst`. This is the software-reset request.
- R8: While disarmed, and without a control write that sets bit 7, `wd_rst` stays low.
- R9: `wd_rst` is registered. It is high for exactly one cycle, the cycle after the edge on which the event was taken.
- R10: The early-warning flag is set on the tick that moves the count from 0x41 to 0x40, whether armed or not. Writing 0 to status bit 0 clears it, and writing 1 has no effect. `ew_irq` is high exactly when the flag and the interrupt-enable bit are both set.
- R11: After rst_n, the register fields are: count 0x7F, window 0x7F, psel 0, interrupt enable 0, flag 0, arm 0 (strap low).
- R12: The register map is as follows:
  - Address 0 (control): count in [6:0], arm in [7].
  - Address 1 (configuration): window in [6:0], psel in [9:7], interrupt enable in [10].
  - Address 2 (status): flag in [0].
  - Unused read bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| hw_arm | input | 1 | Strap: forces the watchdog armed |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| wd_rst | output | 1 | One-cycle reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
Reload writes are issued at random delays against random window values, with the count read in the same cycle as the write. The expected outcome therefore depends only on whether that count lies above the window, which separates premature reloads from valid ones. Directed reloads at a count exactly equal to the window and one above it pin down the comparison edge.

Timeouts are measured from the reload edge under several prescaler settings. Arrival must fall inside a one-period band, which tells a correct tick rate and tick count apart from an off-by-one, and from a divider that restarts on writes. Separate patterns distinguish the cases that must not reset (disarmed writes with bit 6 clear, writes with the arm bit clear) from the software-reset write and the strap-armed case.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int FIX_DIV = 4096,
  parameter int PS_W    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_arm,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        wd_rst,
  output logic        ew_irq
);
  // PS_W must stay at or below 3 to fit the configuration field layout.
  localparam int FIX_W = $clog2(FIX_DIV);
  localparam int PRE_N = (1 << PS_W) - 1;
  localparam logic [6:0] CNT_INIT = 7'h7F;
  localparam logic [6:0] WARN_AT  = 7'h41;
  localparam logic [6:0] LAST_OK  = 7'h40;

  logic [FIX_W-1:0] fix_q;
  logic [PRE_N-1:0] pre_q;
  logic [6:0]       cnt_q, win_q;
  logic [PS_W-1:0]  psel_q;
  logic             ewen_q, flag_q, arm_q;

  wire wr_ctrl = reg_wr && (reg_addr == 2'd0);
  wire wr_cfg  = reg_wr && (reg_addr == 2'd1);
  wire wr_stat = reg_wr && (reg_addr == 2'd2);

  wire arm_eff = arm_q | hw_arm;
  wire arm_nxt = arm_eff | (wr_ctrl & reg_wdata[7]);

  wire [PRE_N-1:0] ps_mask = (PRE_N'(1) << psel_q) - PRE_N'(1);
  wire base_tick = (fix_q == FIX_W'(FIX_DIV - 1));
  wire tick      = base_tick && ((pre_q & ps_mask) == ps_mask);

  wire bad_write = wr_ctrl && arm_nxt && ((cnt_q > win_q) || !reg_wdata[6]);
  wire expire    = !wr_ctrl && tick && arm_eff && (cnt_q == LAST_OK);
  wire warn_set  = !wr_ctrl && tick && (cnt_q == WARN_AT);

  wire unused_bits = ^reg_wdata[15:11];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fix_q  <= '0;
      pre_q  <= '0;
      cnt_q  <= CNT_INIT;
      win_q  <= CNT_INIT;
      psel_q <= '0;
      ewen_q <= 1'b0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      wd_rst <= 1'b0;
    end else begin
      fix_q <= base_tick ? '0 : fix_q + FIX_W'(1);
      if (base_tick) pre_q <= pre_q + PRE_N'(1);

      if (wr_ctrl)   cnt_q <= reg_wdata[6:0];
      else if (tick) cnt_q <= cnt_q - 7'd1;

      if (wr_ctrl && reg_wdata[7]) arm_q <= 1'b1;

      if (wr_cfg) begin
        win_q  <= reg_wdata[6:0];
        psel_q <= reg_wdata[7 +: PS_W];
        ewen_q <= reg_wdata[10];
      end

      if (warn_set)                        flag_q <= 1'b1;
      else if (wr_stat && !reg_wdata[0])   flag_q <= 1'b0;

      wd_rst <= bad_write | expire;
    end
  end

  assign ew_irq = flag_q & ewen_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[7:0] = {arm_eff, cnt_q};
      2'd1: begin
        reg_rdata[6:0]         = win_q;
        reg_rdata[7 +: PS_W]   = psel_q;
        reg_rdata[10]          = ewen_q;
      end
      2'd2: reg_rdata[0] = flag_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hw_arm,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        wd_rst,
  input logic        tick,
  input logic        arm_q,
  input logic        flag_q,
  input logic [6:0]  cnt_q,
  input logic [6:0]  win_q
);
  wire ctrl_wr = reg_wr && (reg_addr == 2'd0);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 7'd1));

  p_arm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);

  p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_q || hw_arm) && tick && cnt_q == 7'h40 && !ctrl_wr) |=> wd_rst);

  p_early_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (arm_q || hw_arm) && cnt_q > win_q) |=> wd_rst);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(arm_q || hw_arm) && !(ctrl_wr && reg_wdata[7])) |=> !wd_rst);

  p_flag_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> cnt_q == 7'h40);
endmodule

bind win_watchdog win_watchdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hw_arm(hw_arm), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wd_rst(wd_rst),
  .tick(tick), .arm_q(arm_q), .flag_q(flag_q), .cnt_q(cnt_q), .win_q(win_q)
);

// File: tb/win_watchdog_tb_top.sv
`timescale 1ns/1ps
module win_watchdog_tb_top;
  localparam int FIX = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        hw_arm = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        wd_rst, ew_irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  win_watchdog #(.FIX_DIV(FIX), .PS_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_arm(hw_arm), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wd_rst(wd_rst), .ew_irq(ew_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int period(input int ps);
    return FIX << ps;
  endfunction

  task automatic do_reset(input bit hw);
    @(negedge clk);
    rst_n = 0; hw_arm = hw; reg_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr_seen(input logic [15:0] d, output logic [6:0] seen);
    @(negedge clk);
    reg_addr = 0; reg_wdata = d; reg_wr = 1;
    #1 seen = reg_rdata[6:0];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic timeout_run(input logic [6:0] v, input int ps);
    int n, p, c;
    n = int'(v) - 'h3F; p = period(ps); c = 0;
    do_reset(0);
    wr(1, {5'b0, 1'b0, 3'(ps), 7'h7F});
    wr(0, {8'h00, 1'b1, v});
    chk(wd_rst == 0, "R6 reload inside window", wd_rst, 0);
    while (c < n * p + 10) begin
      @(negedge clk); c++;
      if (wd_rst) break;
    end
    chk(c >= (n - 1) * p + 1 && c <= n * p, "R5/R2 timeout cycles", c, n * p);
    @(negedge clk);
    chk(wd_rst == 0, "R9 pulse width", wd_rst, 0);
  endtask

  initial begin
    logic [15:0] v;
    logic [6:0]  c0, seen, w;
    void'($urandom(32'h5EED1));

    // Reset values
    do_reset(0);
    rd(0, v); chk(v == 16'h007F, "R11 ctrl after reset", v, 16'h007F);
    rd(1, v); chk(v == 16'h007F, "R11 cfg after reset", v, 16'h007F);
    rd(2, v); chk(v == 16'h0000, "R11 status after reset", v, 0);
    rd(3, v); chk(v == 16'h0000, "R12 unused address", v, 0);
    chk(wd_rst == 0 && ew_irq == 0, "R11 outputs after reset", {wd_rst, ew_irq}, 0);

    // Free running while disarmed, two prescaler settings
    rd(0, v); c0 = v[6:0];
    repeat (5 * FIX) @(negedge clk);
    rd(0, v); chk(v[6:0] == c0 - 7'd5, "R1 free-run psel0", v[6:0], c0 - 7'd5);
    wr(1, 16'h01FF);
    rd(1, v); chk(v == 16'h01FF, "R12 cfg readback", v, 16'h01FF);
    rd(0, v); c0 = v[6:0];
    repeat (2 * period(3)) @(negedge clk);
    rd(0, v); chk(v[6:0] == c0 - 7'd2, "R2 free-run psel3", v[6:0], c0 - 7'd2);

    // Disarmed write with bit 6 clear: no reset
    wr(0, 16'h0020);
    chk(wd_rst == 0, "R8 disarmed write no pulse", wd_rst, 0);
    rd(0, v); chk(v[7:0] == 8'h20, "R1 reload value disarmed", v[7:0], 8'h20);

    // Wrap from 0x00 to 0x7F
    wr(1, 16'h007F);
    wr(0, 16'h0000);
    repeat (FIX + 1) @(negedge clk);
    rd(0, v); chk(v[6:0] == 7'h7F, "R1 wrap", v[6:0], 7'h7F);

    // Arming is sticky
    do_reset(0);
    wr(0, 16'h00FF);
    chk(wd_rst == 0, "R3 arming write no pulse", wd_rst, 0);
    rd(0, v); chk(v[7] == 1, "R3 armed", v[7], 1);
    wr(0, 16'h007F);
    chk(wd_rst == 0, "R3 arm-clear write no pulse", wd_rst, 0);
    rd(0, v); chk(v[7] == 1, "R3 arm stays set", v[7], 1);

    // Software reset
    wr(0, 16'h00BF);
    chk(wd_rst == 1, "R7 software reset pulse", wd_rst, 1);
    @(negedge clk);
    chk(wd_rst == 0, "R9 single cycle", wd_rst, 0);
    do_reset(0);
    wr(0, 16'h00BF);
    chk(wd_rst == 1, "R7 arm and bit6 clear in one write", wd_rst, 1);

    // Timeouts
    timeout_run(7'h45, 0);
    timeout_run(7'h42, 2);
    timeout_run(7'h41, 7);

    // Premature reload
    do_reset(0);
    wr(0, 16'h00FF);
    wr(1, 16'h0060);
    wr_seen(16'h00D0, seen);
    chk(seen > 7'h60 && wd_rst == 1, "R6 premature reload", wd_rst, 1);

    // Boundary: count equal to window, then one above
    for (int k = 0; k < 2; k++) begin
      logic [6:0] target;
      target = (k == 0) ? 7'h7C : 7'h7D;
      do_reset(0);
      wr(0, 16'h00FF);
      wr(1, 16'h007C);
      for (int t = 0; t < 200; t++) begin
        @(negedge clk);
        reg_addr = 0; #1;
        if (reg_rdata[6:0] == target) begin
          reg_wdata = 16'h00D0; reg_wr = 1;
          break;
        end
      end
      @(negedge clk); reg_wr = 0;
      if (k == 0) chk(wd_rst == 0, "R6 count equal to window", wd_rst, 0);
      else        chk(wd_rst == 1, "R6 count one above window", wd_rst, 1);
    end

    // Early warning flag and interrupt
    do_reset(0);
    wr(1, 16'h047F);
    wr(0, 16'h0043);
    for (int t = 0; t < 100; t++) begin
      rd(2, v);
      if (v[0]) break;
      @(negedge clk);
    end
    rd(0, v); chk(v[6:0] == 7'h40, "R10 flag at 0x40", v[6:0], 7'h40);
    chk(ew_irq == 1, "R10 irq with enable", ew_irq, 1);
    wr(2, 16'h0000);
    rd(2, v); chk(v[0] == 0 && ew_irq == 0, "R10 clear by write 0", v[0], 0);
    wr(0, 16'h0042);
    for (int t = 0; t < 100; t++) begin
      rd(2, v);
      if (v[0]) break;
      @(negedge clk);
    end
    wr(2, 16'h0001);
    rd(2, v); chk(v[0] == 1, "R10 write 1 ignored", v[0], 1);
    wr(1, 16'h007F);
    chk(ew_irq == 0, "R10 irq masked", ew_irq, 0);

    // Strap-armed
    do_reset(1);
    rd(0, v); chk(v[7:0] == 8'hFF, "R4 armed from reset", v[7:0], 8'hFF);
    wr(0, 16'h003F);
    chk(wd_rst == 1, "R4 strap armed software reset", wd_rst, 1);
    rd(0, v); chk(v[7] == 1, "R4 stays armed", v[7], 1);

    // Random reload timing against random windows
    for (int it = 0; it < 40; it++) begin
      logic [6:0] rv;
      int wait_c;
      do_reset(0);
      w  = 7'h41 + 7'($urandom % 63);
      rv = 7'h41 + 7'($urandom % 63);
      wait_c = $urandom % 200;
      wr(0, 16'h00FF);
      wr(1, {9'b0, w});
      repeat (wait_c) @(negedge clk);
      wr_seen({8'h00, 1'b1, rv}, seen);
      if (seen > w) begin
        chk(wd_rst == 1, "R6 random premature", wd_rst, 1);
      end else begin
        chk(wd_rst == 0, "R6 random in window", wd_rst, 0);
        rd(0, v); chk(v[6:0] == rv, "R1 random reload", v[6:0], rv);
      end
      @(negedge clk);
      chk(wd_rst == 0, "R9 random pulse width", wd_rst, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule